// File: doc/BRIEF.md
# Two-Wire Converter Result Port

This block is the device-side logic of a two-wire result port for a delta-sigma converter. The host drives one clock pin. The block drives one line that first tells the host a result is ready and then carries the bits of that result. The conversion filter hands the block each finished result with a one-cycle strobe. The block holds the line high for a short update window, then pulls it low to signal ready. Each host clock rising edge after that presents the next result bit, most significant first.

Commands reach the block only through the host clock. Extra edges after a full readout raise the line again and request a self-calibration. Holding the clock high for a long time puts the block in standby, and letting it fall wakes the block up. The block also watches three front-end select inputs. When any of them changes, it restarts the filter and keeps the line high until a settled result arrives. The host clock is synchronised into the system clock domain, and all edges are detected on the synchronised copy.

Top module: `adc2w_link`

## Requirements
- R1: While reset is applied and right after it is released, `dout_o` is 1 and `standby_o`, `cal_start_o` and `flt_restart_o` are 0.
- R2: A strobe on `res_valid_i` drives `dout_o` to 1 for an update window of UPD_CYC cycles. Host clock edges are ignored during the window. The line then goes to 0 to mark the result as ready.
- R3: Once the line is low, each synchronised rising edge of `sclk_i` places the next result bit on `dout_o`, starting with bit W-1 and ending with bit 0. That gives W bits for W edges.
- R4: After bit 0 has been shifted out, `dout_o` keeps that bit's level until the next result strobe. The strobe forces the line to 1.
- R5: Rising edge W+1 of a readout drives `dout_o` to 1.
- R6: The falling edge that follows rising edge W+2 of a readout makes `cal_start_o` 1 for one cycle and holds `dout_o` at 1. Result strobes are then ignored until `cal_done_i` is seen. The next result after that goes through the normal window and ready sequence.
- R7: If the synchronised `sclk_i` stays high for STBY_CYC consecutive cycles outside calibration, `standby_o` goes to 1 and `dout_o` to 1. Result strobes are ignored while in standby.
- R8: A falling edge of `sclk_i` in standby clears `standby_o` and pulses exactly one of two outputs. It pulses `cal_start_o` if at least W+1 rising edges had been shifted in the readout before standby, and `flt_restart_o` otherwise.
- R9: A change of `ch_sel_i`, `buf_en_i` or `temp_en_i` outside calibration and standby pulses `flt_restart_o` and forces `dout_o` to 1. Any result not yet presented is discarded, and the line stays high until the next result strobe and its window.
- R10: A result strobe that arrives during a readout overwrites the old result without any flag. The line goes to 1, a new window runs, and the new result is then presented from its bit W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| res_data_i | input | W | Result word from the filter, two's complement |
| res_valid_i | input | 1 | One-cycle strobe: a new result is on `res_data_i` |
| cal_done_i | input | 1 | Calibration routine has finished |
| ch_sel_i | input | 1 | Input channel select |
| buf_en_i | input | 1 | Input buffer enable |
| temp_en_i | input | 1 | Temperature sensor select |
| dout_o | output | 1 | Ready flag (low) and serial data line |
| standby_o | output | 1 | High while in standby |
| cal_start_o | output | 1 | One-cycle request to start self-calibration |
| flt_restart_o | output | 1 | One-cycle request to restart the filter |

## Verification
A host clock change passes through SYNC_STAGES synchroniser flops and one state register. With the default of two stages, `dout_o` therefore reflects an edge three system cycles later. The bench holds each host clock level for six cycles and samples the line on a falling system clock edge at the end of that hold. A result strobe shows on the line one cycle later, and the ready level shows UPD_CYC+1 cycles later. The bench checks the high level three cycles after a strobe and the low level fifteen cycles after it. Standby needs STBY_CYC+3 cycles of high host clock, so the bench holds the clock high for 30 cycles to check that standby does not start and for 100 cycles to check that it does. Command pulses are counted on every falling system clock edge and compared a few cycles after the host edge that triggers them.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;
   typedef enum logic [2:0] {
      ST_WAIT = 3'd0,
      ST_UPD  = 3'd1,
      ST_RDY  = 3'd2,
      ST_CAL  = 3'd3,
      ST_STBY = 3'd4
   } adc2w_st_e;
endpackage

// File: rtl/adc2w_sync.sv
module adc2w_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] pipe_q;
   logic              prev_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe_q[0] <= 1'b0;
            else        pipe_q[0] <= async_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe_q[g] <= 1'b0;
            else        pipe_q[g] <= pipe_q[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pipe_q[STAGES-1];

   assign lvl_o  = pipe_q[STAGES-1];
   assign rise_o = pipe_q[STAGES-1] & ~prev_q;
   assign fall_o = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc2w_timer.sv
module adc2w_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cnt_q <= '0;
      else if (!run_i)  cnt_q <= '0;
      else if (!done_o) cnt_q <= cnt_q + 1'b1;

   assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/adc2w_link.sv
module adc2w_link
   import adc2w_pkg::*;
#(
   parameter int W           = 24,
   parameter int SYNC_STAGES = 2,
   parameter int UPD_CYC     = 96,
   parameter int STBY_CYC    = 16640
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclk_i,
   input  logic [W-1:0] res_data_i,
   input  logic         res_valid_i,
   input  logic         cal_done_i,
   input  logic         ch_sel_i,
   input  logic         buf_en_i,
   input  logic         temp_en_i,
   output logic         dout_o,
   output logic         standby_o,
   output logic         cal_start_o,
   output logic         flt_restart_o
);
   localparam int CNT_W = $clog2(W + 3);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W);
   localparam logic [CNT_W-1:0] FORCE_HI = CNT_W'(W + 1);
   localparam logic [CNT_W-1:0] CAL_ARM  = CNT_W'(W + 2);

   if (W < 2) begin : g_bad_w
      $error("adc2w_link: W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("adc2w_link: SYNC_STAGES must be at least 2");
   end
   if (UPD_CYC < 1 || STBY_CYC < 2) begin : g_bad_time
      $error("adc2w_link: UPD_CYC >= 1 and STBY_CYC >= 2 required");
   end

   adc2w_st_e        st_q;
   logic [W-1:0]     sh_q, pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic             dout_q, cal_flag_q, cal_q, restart_q;
   logic [2:0]       cfg_q;
   logic             sclk_lvl, sclk_rise, sclk_fall;
   logic             upd_done, stby_hit, active, cfg_chg;
   logic [2:0]       cfg_now;

   adc2w_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(sclk_i),
      .lvl_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall)
   );

   assign active  = (st_q == ST_WAIT) || (st_q == ST_UPD) || (st_q == ST_RDY);
   assign cfg_now = {temp_en_i, buf_en_i, ch_sel_i};
   assign cfg_chg = (cfg_now != cfg_q);

   adc2w_timer #(.LIMIT(UPD_CYC)) upd_tmr_i (
      .clk(clk), .rst_n(rst_n),
      .run_i((st_q == ST_UPD) && !res_valid_i), .done_o(upd_done)
   );

   adc2w_timer #(.LIMIT(STBY_CYC)) stby_tmr_i (
      .clk(clk), .rst_n(rst_n),
      .run_i(sclk_lvl && active), .done_o(stby_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_WAIT;
         sh_q       <= '0;
         pend_q     <= '0;
         cnt_q      <= '0;
         dout_q     <= 1'b1;
         cal_flag_q <= 1'b0;
         cal_q      <= 1'b0;
         restart_q  <= 1'b0;
         cfg_q      <= '0;
      end else begin
         cfg_q     <= cfg_now;
         cal_q     <= 1'b0;
         restart_q <= 1'b0;
         if (active && cfg_chg) begin
            restart_q <= 1'b1;
            st_q      <= ST_WAIT;
            dout_q    <= 1'b1;
            cnt_q     <= '0;
         end else if (active && stby_hit) begin
            st_q       <= ST_STBY;
            dout_q     <= 1'b1;
            cal_flag_q <= (st_q == ST_RDY) && (cnt_q >= FORCE_HI);
         end else begin
            unique case (st_q)
               ST_WAIT: begin
                  if (res_valid_i) begin
                     pend_q <= res_data_i;
                     st_q   <= ST_UPD;
                     dout_q <= 1'b1;
                  end
               end
               ST_UPD: begin
                  if (res_valid_i) begin
                     pend_q <= res_data_i;
                  end else if (upd_done) begin
                     sh_q   <= pend_q;
                     cnt_q  <= '0;
                     dout_q <= 1'b0;
                     st_q   <= ST_RDY;
                  end
               end
               ST_RDY: begin
                  if (res_valid_i) begin
                     pend_q <= res_data_i;
                     st_q   <= ST_UPD;
                     dout_q <= 1'b1;
                  end else if (sclk_rise) begin
                     if (cnt_q < LAST_BIT) begin
                        dout_q <= sh_q[W-1];
                        sh_q   <= {sh_q[W-2:0], 1'b0};
                        cnt_q  <= cnt_q + 1'b1;
                     end else if (cnt_q == LAST_BIT) begin
                        dout_q <= 1'b1;
                        cnt_q  <= cnt_q + 1'b1;
                     end else if (cnt_q == FORCE_HI) begin
                        cnt_q  <= cnt_q + 1'b1;
                     end
                  end else if (sclk_fall && cnt_q == CAL_ARM) begin
                     cal_q  <= 1'b1;
                     st_q   <= ST_CAL;
                     dout_q <= 1'b1;
                     cnt_q  <= '0;
                  end
               end
               ST_CAL: begin
                  if (cal_done_i) st_q <= ST_WAIT;
               end
               ST_STBY: begin
                  if (sclk_fall) begin
                     if (cal_flag_q) begin
                        cal_q <= 1'b1;
                        st_q  <= ST_CAL;
                     end else begin
                        restart_q <= 1'b1;
                        st_q      <= ST_WAIT;
                     end
                     cal_flag_q <= 1'b0;
                     cnt_q      <= '0;
                  end
               end
               default: st_q <= ST_WAIT;
            endcase
         end
      end
   end

   assign dout_o        = dout_q;
   assign standby_o     = (st_q == ST_STBY);
   assign cal_start_o   = cal_q;
   assign flt_restart_o = restart_q;
endmodule

// File: rtl/adc2w_link_chk.sv
module adc2w_link_chk
   import adc2w_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      dout_o,
   input logic      standby_o,
   input logic      cal_start_o,
   input logic      flt_restart_o,
   input logic      ch_sel_i,
   input logic      buf_en_i,
   input logic      temp_en_i,
   input adc2w_st_e st_q
);
   logic [2:0] cfg;
   assign cfg = {temp_en_i, buf_en_i, ch_sel_i};

   a_r2_window_high: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_UPD) |-> dout_o);

   a_r6_cal_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |-> dout_o);

   a_r6_cal_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |=> !cal_start_o);

   a_r7_standby_high: assert property (@(posedge clk) disable iff (!rst_n)
      standby_o |-> dout_o);

   a_r8_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(standby_o) |-> (cal_start_o || flt_restart_o));

   a_r8_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_start_o && flt_restart_o));

   a_r9_cfg_restart: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg != $past(cfg)) && (st_q == ST_WAIT || st_q == ST_UPD || st_q == ST_RDY))
      |=> flt_restart_o);
endmodule

bind adc2w_link adc2w_link_chk chk_i (
   .clk(clk), .rst_n(rst_n), .dout_o(dout_o), .standby_o(standby_o),
   .cal_start_o(cal_start_o), .flt_restart_o(flt_restart_o),
   .ch_sel_i(ch_sel_i), .buf_en_i(buf_en_i), .temp_en_i(temp_en_i),
   .st_q(st_q)
);

// File: tb/adc2w_link_tb.sv
module adc2w_link_tb_top;
   localparam int W = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk = 1'b0;
   logic [W-1:0] res_data = '0;
   logic         res_valid = 1'b0;
   logic         cal_done = 1'b0;
   logic         ch_sel = 1'b0, buf_en = 1'b0, temp_en = 1'b0;
   logic         dout, standby, cal_start, flt_restart;

   int n_chk = 0, n_fail = 0, n_cal = 0, n_rst = 0;
   bit finished = 0;

   typedef struct { logic v; string tag; } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   adc2w_link #(.W(W), .SYNC_STAGES(2), .UPD_CYC(8), .STBY_CYC(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .res_data_i(res_data),
      .res_valid_i(res_valid), .cal_done_i(cal_done), .ch_sel_i(ch_sel),
      .buf_en_i(buf_en), .temp_en_i(temp_en), .dout_o(dout),
      .standby_o(standby), .cal_start_o(cal_start), .flt_restart_o(flt_restart)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (cal_start)   n_cal++;
         if (flt_restart) n_rst++;
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push_word(logic [W-1:0] d, int n, string tag);
      for (int i = 0; i < n; i++) exp_q.push_back('{d[W-1-i], tag});
   endtask

   task automatic mon_pop();
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, {31'd0, dout}, {31'd0, e.v});
   endtask

   task automatic pulses(int n, bit cmp);
      for (int k = 0; k < n; k++) begin
         sclk = 1'b1;
         wait_n(6);
         if (cmp) mon_pop();
         sclk = 1'b0;
         wait_n(6);
      end
   endtask

   task automatic send(logic [W-1:0] d);
      res_data  = d;
      res_valid = 1'b1;
      wait_n(1);
      res_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int c0, r0;
      wait_n(3);
      chk("R1 dout in reset", {31'd0, dout}, 1);
      rst_n = 1'b1;
      wait_n(2);
      chk("R1 dout", {31'd0, dout}, 1);
      chk("R1 standby", {31'd0, standby}, 0);
      chk("R1 pulses", n_cal + n_rst, 0);

      // R2 window and ready, R3 readout
      send(24'hA53C96);
      wait_n(3);
      chk("R2 window high", {31'd0, dout}, 1);
      wait_n(12);
      chk("R2 ready low", {31'd0, dout}, 0);
      push_word(24'hA53C96, W, "R3 bit");
      pulses(W, 1);
      // R4 hold of last bit
      wait_n(20);
      chk("R4 hold last bit", {31'd0, dout}, 0);
      // R5 extra edge forces high
      sclk = 1'b1; wait_n(6);
      chk("R5 edge 25 high", {31'd0, dout}, 1);
      sclk = 1'b0; wait_n(6);
      // R6 calibration on falling edge after edge 26
      c0 = n_cal;
      pulses(1, 0);
      chk("R6 cal pulse", n_cal, c0 + 1);
      chk("R6 line high", {31'd0, dout}, 1);
      send(24'h111111);
      wait_n(20);
      chk("R6 result ignored in cal", {31'd0, dout}, 1);
      cal_done = 1'b1; wait_n(1); cal_done = 1'b0;
      wait_n(3);
      chk("R6 high until result", {31'd0, dout}, 1);
      send(24'h5A0F33);
      wait_n(15);
      chk("R6 ready after cal", {31'd0, dout}, 0);
      push_word(24'h5A0F33, W, "R6 bit");
      pulses(W, 1);

      // R10 overwrite during readout
      send(24'h123456);
      wait_n(15);
      push_word(24'h123456, 4, "R10 old bit");
      pulses(4, 1);
      send(24'hC3C3C2);
      wait_n(3);
      chk("R10 line high", {31'd0, dout}, 1);
      wait_n(12);
      chk("R10 ready", {31'd0, dout}, 0);
      push_word(24'hC3C3C2, W, "R10 new bit");
      pulses(W, 1);
      wait_n(20);
      chk("R4 hold last bit", {31'd0, dout}, 0);
      send(24'h7E81FF);
      wait_n(3);
      chk("R4 update forces high", {31'd0, dout}, 1);
      wait_n(12);
      chk("R2 ready low", {31'd0, dout}, 0);

      // R7 standby entry threshold
      sclk = 1'b1; wait_n(30);
      chk("R7 short high no standby", {31'd0, standby}, 0);
      sclk = 1'b0; wait_n(6);
      sclk = 1'b1; wait_n(100);
      chk("R7 standby", {31'd0, standby}, 1);
      chk("R7 line high", {31'd0, dout}, 1);
      send(24'h222222);
      wait_n(20);
      chk("R7 result ignored", {31'd0, dout}, 1);
      r0 = n_rst; c0 = n_cal;
      sclk = 1'b0; wait_n(8);
      chk("R8 wake", {31'd0, standby}, 0);
      chk("R8 restart pulse", n_rst, r0 + 1);
      chk("R8 no cal", n_cal, c0);
      send(24'h0F0F0F);
      wait_n(15);
      chk("R8 ready after wake", {31'd0, dout}, 0);
      push_word(24'h0F0F0F, W, "R3 bit");
      pulses(W, 1);

      // R8 calibration on wake after W+1 edges
      sclk = 1'b1; wait_n(6);
      chk("R5 edge 25 high", {31'd0, dout}, 1);
      sclk = 1'b0; wait_n(6);
      sclk = 1'b1; wait_n(100);
      chk("R7 standby again", {31'd0, standby}, 1);
      r0 = n_rst; c0 = n_cal;
      sclk = 1'b0; wait_n(8);
      chk("R8 cal on wake", n_cal, c0 + 1);
      chk("R8 no restart", n_rst, r0);
      cal_done = 1'b1; wait_n(1); cal_done = 1'b0;
      send(24'h818181);
      wait_n(15);
      chk("R6 ready after wake cal", {31'd0, dout}, 0);

      // R9 config change
      r0 = n_rst;
      ch_sel = 1'b1;
      wait_n(4);
      chk("R9 restart pulse", n_rst, r0 + 1);
      chk("R9 line high", {31'd0, dout}, 1);
      wait_n(30);
      chk("R9 unread result dropped", {31'd0, dout}, 1);
      send(24'hFEDCBA);
      wait_n(15);
      chk("R9 ready after settle", {31'd0, dout}, 0);
      push_word(24'hFEDCBA, 8, "R9 bit");
      pulses(8, 1);

      finish_run();
   end
endmodule